// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control store of a multi-channel DMA controller. A simple word-addressed bus (select, write strobe, byte address, write data, registered read data) reaches a set of global registers and a group of per-channel bit vectors. Those vectors drive the request logic and the sequencer: single-request blocking, request masking, channel enable, alternate descriptor select and high priority. Software changes each vector through a pair of addresses. A 1 written at the set address turns channel bits on, and a 1 written at the clear address turns them off. No read-modify-write sequence is needed.

The block also holds a global enable and a three-bit bus protection field. It holds the descriptor table base pointer, which is aligned to 1 KiB, and computes the alternate table base from it. A software request register produces one-cycle request pulses. A sticky done register is cleared by writing 1, and a bus-error flag behaves the same way. A done mask register decides whether each channel's done and active indications reach its peripheral or count towards the combined done output. The sequencer state, the done pulses and a bus-error pulse come back into the block for readback.

Top module: `dmactl_regbank`

## Requirements
- R1: After a synchronous active-low reset, every channel vector, the enable, the protection field, the base pointer, the done bits, the done mask and the error flag are 0.
- R2: Channel vectors have set/clear address pairs, with bit index = channel. The pairs are: single-request block 0x018/0x01C, request mask 0x020/0x024, enable 0x028/0x02C, alternate select 0x030/0x034, high priority 0x038/0x03C. A 1 at the set address sets the bit, a 1 at the clear address clears it, and 0 bits change nothing. Reading the set address returns the vector, and reading the clear address returns 0.
- R3: Bits above NUM_CH-1 are ignored on every write and read as 0.
- R4: Status (0x000) reads bits [31:28]=0, [20:16]=NUM_CH-1, [7:4]=seq_state, [0]=global enable, and all other bits 0.
- R5: Config (0x004) bit 0 is the global enable and bits [7:5] drive prot_bits[2:0]. Other bits read 0.
- R6: The base pointer (0x008) keeps write bits [31:10] and reads bits [9:0] as 0. The alternate base (0x00C) is read-only and equals the base pointer plus NUM_CH*16.
- R7: Writing 0x014 puts a one-cycle pulse on ch_sw_req for each 1 bit, in the cycle after the write. Reads of 0x014 return 0.
- R8: Each done bit (0x504) is set by its ch_done_pulse and cleared only by writing 1. A done pulse and a clear in the same cycle leave the bit set.
- R9: The error flag (0x04C bit 0) is set by bus_err_pulse and cleared by writing 1. Writing 0 leaves it unchanged, and a pulse together with a clear leaves it set.
- R10: The done mask (0x520) is a read/write vector. A mask bit of 0 passes that channel's ch_done_pulse and ch_active to periph_done and periph_active. A mask bit of 1 blocks them. irq_done is 1 when any done bit with mask 1 is set.
- R11: Unmapped addresses read as 0 and ignore writes.
- R12: Wait-on-request (0x010) reads the WAIT_ON_REQ parameter, drives ch_wait_req, and ignores writes.
- R13: bus_rdata takes the addressed value at the clock edge that samples a read, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| seq_state | input | 4 | Sequencer state for readback |
| ch_done_pulse | input | NUM_CH | Per-channel completion pulses |
| ch_active | input | NUM_CH | Per-channel active indications |
| bus_err_pulse | input | 1 | Bus error event |
| master_en | output | 1 | Global enable |
| prot_bits | output | 3 | Bus protection (cacheable, bufferable, privileged) |
| base_ptr | output | 32 | Primary descriptor table base |
| alt_base | output | 32 | Alternate descriptor table base |
| ch_wait_req | output | NUM_CH | Hold channel active until request drops |
| ch_burst_only | output | NUM_CH | Single requests ignored |
| ch_req_mask | output | NUM_CH | External requests masked |
| ch_enable | output | NUM_CH | Channel enabled |
| ch_use_alt | output | NUM_CH | Alternate descriptor selected |
| ch_hi_prio | output | NUM_CH | High priority |
| ch_sw_req | output | NUM_CH | Software request pulses |
| periph_done | output | NUM_CH | Done routed to peripherals |
| periph_active | output | NUM_CH | Active routed to peripherals |
| irq_done | output | 1 | Combined done |
| err_flag | output | 1 | Sticky bus error |

## Verification
Register writes, done and error events, and software request pulses are all due one cycle after the clock edge that samples them. Read data is due in the cycle right after the read strobe. The mask routing onto periph_done and periph_active is combinational and is due in the same cycle as its input. The bench drives every input on the falling edge, so the next rising edge takes it. Registered results are sampled on the following falling edge, and combinational routing is sampled a short delay after the inputs change. The software request pulse is sampled twice, in the cycle it is due and in the cycle after, to confirm it lasts one cycle.

// File: rtl/dmactl_pkg.sv
// Package: address map, bus constants and write strobe type shared by the
// register bank, its decoder and its checker.
package dmactl_pkg;

    localparam int AW     = 12;
    localparam int DW     = 32;
    localparam int NUM_SC = 5;    // number of set/clear channel vectors

    localparam logic [AW-1:0] OFS_STATUS = 12'h000;
    localparam logic [AW-1:0] OFS_CFG    = 12'h004;
    localparam logic [AW-1:0] OFS_BASE   = 12'h008;
    localparam logic [AW-1:0] OFS_ALT    = 12'h00C;
    localparam logic [AW-1:0] OFS_WAIT   = 12'h010;
    localparam logic [AW-1:0] OFS_SWREQ  = 12'h014;
    localparam logic [AW-1:0] OFS_SC0    = 12'h018;   // first set address; pairs step by 8
    localparam logic [AW-1:0] OFS_ERR    = 12'h04C;
    localparam logic [AW-1:0] OFS_DONE   = 12'h504;
    localparam logic [AW-1:0] OFS_DMASK  = 12'h520;

    // Channel vector index order (position gives set address OFS_SC0 + 8*i)
    localparam int SC_BURST = 0;
    localparam int SC_RMASK = 1;
    localparam int SC_EN    = 2;
    localparam int SC_ALT   = 3;
    localparam int SC_PRIO  = 4;

    typedef struct packed {
        logic              cfg;
        logic              base;
        logic              swreq;
        logic              err;
        logic              done;
        logic              dmask;
        logic [NUM_SC-1:0] set;
        logic [NUM_SC-1:0] clr;
    } wr_strobe_t;

    // Set address of channel vector i
    function automatic logic [AW-1:0] sc_set_addr(input int i);
        return OFS_SC0 + AW'(8 * i);
    endfunction

endpackage

// File: rtl/dmactl_addr_dec.sv
// Module: write address decoder.
// Turns one bus write into at most one write strobe. It assumes word-aligned
// byte addresses: a misaligned or unmapped address raises no strobe.
module dmactl_addr_dec
    import dmactl_pkg::*;
(
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output wr_strobe_t    wstb
);

    // Decode the write address into one strobe
    always_comb begin
        wstb = '0;
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                OFS_CFG:   wstb.cfg   = 1'b1;
                OFS_BASE:  wstb.base  = 1'b1;
                OFS_SWREQ: wstb.swreq = 1'b1;
                OFS_ERR:   wstb.err   = 1'b1;
                OFS_DONE:  wstb.done  = 1'b1;
                OFS_DMASK: wstb.dmask = 1'b1;
                default:   ;
            endcase
            for (int i = 0; i < NUM_SC; i++) begin
                if (bus_addr == sc_set_addr(i))
                    wstb.set[i] = 1'b1;
                if (bus_addr == sc_set_addr(i) + AW'(4))
                    wstb.clr[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmactl_setclr_vec.sv
// Module: one per-channel bit vector updated through set and clear strobes.
// Ones in wdata set bits (set_we) or clear bits (clr_we), and zeros leave bits
// alone. It assumes the two strobes are never high in the same cycle.
module dmactl_setclr_vec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    // Gate write data with the strobes
    always_comb begin
        set_m = set_we ? wdata : '0;
        clr_m = clr_we ? wdata : '0;
    end

    // Hold the vector; apply set then clear masks
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_m) & ~clr_m;
    end

endmodule

// File: rtl/dmactl_done_bank.sv
// Module: sticky done bits, done mask and peripheral routing.
// Done bits clear on a written 1, and a completion in the same cycle wins.
// A mask bit of 0 routes the done and active signals to the peripheral. A mask
// bit of 1 blocks them and lets the done bit count in the combined done.
module dmactl_done_bank #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_pulse,
    input  logic [NUM_CH-1:0] active,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] done_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] periph_done,
    output logic [NUM_CH-1:0] periph_active,
    output logic              irq_done
);

    logic [NUM_CH-1:0] clr_m;

    // Clear mask from a done-register write
    always_comb clr_m = clr_we ? wdata : '0;

    // Sticky done bits: set dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= (done_q & ~clr_m) | done_pulse;
    end

    // Done mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Route unmasked channels to peripherals; masked channels to combined done
    always_comb begin
        periph_done   = done_pulse & ~mask_q;
        periph_active = active & ~mask_q;
        irq_done      = |(done_q & mask_q);
    end

endmodule

// File: rtl/dmactl_regbank.sv
// Module: DMA channel control register bank (top).
// Word-addressed register file with set/clear channel vectors, global config,
// descriptor base pointers, software request pulses, sticky done and error
// state. It assumes 1 <= NUM_CH <= 32, so the alternate table (NUM_CH*16
// bytes past the base) stays inside the 1 KiB aligned region.
module dmactl_regbank
    import dmactl_pkg::*;
#(
    parameter int          NUM_CH      = 32,
    parameter logic [31:0] WAIT_ON_REQ = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        seq_state,
    input  logic [NUM_CH-1:0] ch_done_pulse,
    input  logic [NUM_CH-1:0] ch_active,
    input  logic              bus_err_pulse,
    output logic              master_en,
    output logic [2:0]        prot_bits,
    output logic [31:0]       base_ptr,
    output logic [31:0]       alt_base,
    output logic [NUM_CH-1:0] ch_wait_req,
    output logic [NUM_CH-1:0] ch_burst_only,
    output logic [NUM_CH-1:0] ch_req_mask,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] ch_use_alt,
    output logic [NUM_CH-1:0] ch_hi_prio,
    output logic [NUM_CH-1:0] ch_sw_req,
    output logic [NUM_CH-1:0] periph_done,
    output logic [NUM_CH-1:0] periph_active,
    output logic              irq_done,
    output logic              err_flag
);

    localparam int          BASE_LSB = 10;
    localparam int          BASE_W   = 32 - BASE_LSB;
    localparam logic [31:0] ALT_OFS  = 32'(NUM_CH * 16);
    localparam logic [4:0]  CH_M1    = 5'(NUM_CH - 1);

    wr_strobe_t                   wstb;
    logic [NUM_SC-1:0][NUM_CH-1:0] sc_q;
    logic [NUM_CH-1:0]            wdata_ch;
    logic [BASE_W-1:0]            base_q;
    logic [2:0]                   prot_q;
    logic                         en_q;
    logic                         err_q;
    logic [NUM_CH-1:0]            swreq_q;
    logic [NUM_CH-1:0]            done_q;
    logic [NUM_CH-1:0]            dmask_q;
    logic [31:0]                  rd_mux;
    logic [31:0]                  rdata_q;

    // Implemented-channel slice of write data
    always_comb wdata_ch = bus_wdata[NUM_CH-1:0];

    dmactl_addr_dec u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wstb     (wstb)
    );

    // One set/clear vector per channel control
    for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
        dmactl_setclr_vec #(.W(NUM_CH)) u_vec (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (wstb.set[g]),
            .clr_we (wstb.clr[g]),
            .wdata  (wdata_ch),
            .q      (sc_q[g])
        );
    end

    dmactl_done_bank #(.NUM_CH(NUM_CH)) u_done (
        .clk           (clk),
        .rst_n         (rst_n),
        .done_pulse    (ch_done_pulse),
        .active        (ch_active),
        .clr_we        (wstb.done),
        .mask_we       (wstb.dmask),
        .wdata         (wdata_ch),
        .done_q        (done_q),
        .mask_q        (dmask_q),
        .periph_done   (periph_done),
        .periph_active (periph_active),
        .irq_done      (irq_done)
    );

    // Global config: enable and protection bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            prot_q <= 3'b0;
        end else if (wstb.cfg) begin
            en_q   <= bus_wdata[0];
            prot_q <= bus_wdata[7:5];
        end
    end

    // Descriptor base pointer, 1 KiB aligned
    always_ff @(posedge clk) begin
        if (!rst_n)         base_q <= '0;
        else if (wstb.base) base_q <= bus_wdata[31:BASE_LSB];
    end

    // Software request pulses, self-clearing
    always_ff @(posedge clk) begin
        if (!rst_n)          swreq_q <= '0;
        else if (wstb.swreq) swreq_q <= wdata_ch;
        else                 swreq_q <= '0;
    end

    // Sticky bus error flag: event dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_q <= 1'b0;
        else if (bus_err_pulse)              err_q <= 1'b1;
        else if (wstb.err && bus_wdata[0])   err_q <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_STATUS: rd_mux = {4'h0, 7'h0, CH_M1, 8'h0, seq_state, 3'h0, en_q};
            OFS_CFG:    rd_mux = {24'h0, prot_q, 4'h0, en_q};
            OFS_BASE:   rd_mux = base_ptr;
            OFS_ALT:    rd_mux = alt_base;
            OFS_WAIT:   rd_mux[NUM_CH-1:0] = WAIT_ON_REQ[NUM_CH-1:0];
            OFS_ERR:    rd_mux = {31'h0, err_q};
            OFS_DONE:   rd_mux[NUM_CH-1:0] = done_q;
            OFS_DMASK:  rd_mux[NUM_CH-1:0] = dmask_q;
            default:    ;
        endcase
        for (int i = 0; i < NUM_SC; i++) begin
            if (bus_addr == sc_set_addr(i))
                rd_mux[NUM_CH-1:0] = sc_q[i];
        end
    end

    // Registered read data, loaded on each read
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (bus_sel && !bus_wr) rdata_q <= rd_mux;
    end

    // Output assignments
    always_comb begin
        bus_rdata     = rdata_q;
        master_en     = en_q;
        prot_bits     = prot_q;
        base_ptr      = {base_q, {BASE_LSB{1'b0}}};
        alt_base      = base_ptr + ALT_OFS;
        ch_wait_req   = WAIT_ON_REQ[NUM_CH-1:0];
        ch_burst_only = sc_q[SC_BURST];
        ch_req_mask   = sc_q[SC_RMASK];
        ch_enable     = sc_q[SC_EN];
        ch_use_alt    = sc_q[SC_ALT];
        ch_hi_prio    = sc_q[SC_PRIO];
        ch_sw_req     = swreq_q;
        err_flag      = err_q;
    end

endmodule

// File: rtl/dmactl_regbank_chk.sv
// Module: assertion checker for the register bank, bound to every instance.
// It watches bus writes and event inputs against the registered outputs.
module dmactl_regbank_chk
    import dmactl_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [11:0]       bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_err_pulse,
    input logic              err_flag,
    input logic              master_en,
    input logic [31:0]       base_ptr,
    input logic [NUM_CH-1:0] ch_sw_req,
    input logic [NUM_CH-1:0] ch_done_pulse,
    input logic [NUM_CH-1:0] done_q
);

    logic wr_swreq, wr_done, wr_cfg, wr_base;

    // Write-address qualifiers seen by the checker
    always_comb begin
        wr_swreq = bus_sel && bus_wr && (bus_addr == OFS_SWREQ);
        wr_done  = bus_sel && bus_wr && (bus_addr == OFS_DONE);
        wr_cfg   = bus_sel && bus_wr && (bus_addr == OFS_CFG);
        wr_base  = bus_sel && bus_wr && (bus_addr == OFS_BASE);
    end

    AST_SWREQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_sw_req != '0) |-> $past(wr_swreq)); // R7

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done_pulse != '0) |=> ((done_q & $past(ch_done_pulse)) == $past(ch_done_pulse))); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |=> ((done_q & $past(done_q)) == $past(done_q))); // R8

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_pulse |=> err_flag); // R9

    AST_CFG_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (master_en == $past(bus_wdata[0]))); // R5

    AST_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base |=> (base_ptr[31:10] == $past(bus_wdata[31:10]))); // R6

endmodule

bind dmactl_regbank dmactl_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_err_pulse (bus_err_pulse),
    .err_flag      (err_flag),
    .master_en     (master_en),
    .base_ptr      (base_ptr),
    .ch_sw_req     (ch_sw_req),
    .ch_done_pulse (ch_done_pulse),
    .done_q        (done_q)
);

// File: tb/dmactl_regbank_tb.sv
// Bench: vector table of writes and read checks, then directed tests.
// NUM_CH is 24 so that bits of channels that do not exist can be exercised.
module dmactl_regbank_tb;

    localparam int          NCH  = 24;
    localparam logic [31:0] WAIT = 32'h0000_0A0A;
    localparam int          NVEC = 36;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [3:0]      seq_state = '0;
    logic [NCH-1:0]  ch_done_pulse = '0;
    logic [NCH-1:0]  ch_active = '0;
    logic            bus_err_pulse = 1'b0;
    logic            master_en;
    logic [2:0]      prot_bits;
    logic [31:0]     base_ptr, alt_base;
    logic [NCH-1:0]  ch_wait_req, ch_burst_only, ch_req_mask, ch_enable;
    logic [NCH-1:0]  ch_use_alt, ch_hi_prio, ch_sw_req, periph_done, periph_active;
    logic            irq_done, err_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dmactl_regbank #(.NUM_CH(NCH), .WAIT_ON_REQ(WAIT)) u_dut (.*);

    // {requirement, is_read, address, write data or expected read data}
    localparam logic [48:0] VEC [NVEC] = '{
        {4'd2,  1'b0, 12'h028, 32'h0000_00F0},  // R2 set enable 4..7
        {4'd2,  1'b1, 12'h028, 32'h0000_00F0},
        {4'd2,  1'b0, 12'h02C, 32'h0000_0030},  // R2 clear 4,5
        {4'd2,  1'b1, 12'h028, 32'h0000_00C0},
        {4'd2,  1'b0, 12'h028, 32'h0000_0000},  // R2 zeros do nothing
        {4'd2,  1'b1, 12'h028, 32'h0000_00C0},
        {4'd2,  1'b1, 12'h02C, 32'h0000_0000},  // R2 clear address reads 0
        {4'd3,  1'b0, 12'h018, 32'hFFFF_FFFF},  // R3 upper bits dropped
        {4'd3,  1'b1, 12'h018, 32'h00FF_FFFF},
        {4'd2,  1'b0, 12'h01C, 32'hFFFF_0000},
        {4'd2,  1'b1, 12'h018, 32'h0000_FFFF},
        {4'd2,  1'b0, 12'h020, 32'h0000_0005},  // R2 request mask
        {4'd2,  1'b1, 12'h020, 32'h0000_0005},
        {4'd2,  1'b0, 12'h030, 32'h0000_0081},  // R2 alternate select
        {4'd2,  1'b0, 12'h034, 32'h0000_0001},
        {4'd2,  1'b1, 12'h030, 32'h0000_0080},
        {4'd3,  1'b0, 12'h038, 32'h0180_0000},  // R3 bit 24 dropped
        {4'd3,  1'b1, 12'h038, 32'h0080_0000},
        {4'd5,  1'b0, 12'h004, 32'h0000_00FF},  // R5 config
        {4'd5,  1'b1, 12'h004, 32'h0000_00E1},
        {4'd4,  1'b1, 12'h000, 32'h0017_0001},  // R4 status, seq_state 0
        {4'd6,  1'b0, 12'h008, 32'h2000_07FF},  // R6 base
        {4'd6,  1'b1, 12'h008, 32'h2000_0400},
        {4'd6,  1'b1, 12'h00C, 32'h2000_0580},  // R6 alt = base + 24*16
        {4'd6,  1'b0, 12'h00C, 32'h0000_0000},  // R6 read-only
        {4'd6,  1'b1, 12'h00C, 32'h2000_0580},
        {4'd11, 1'b0, 12'h040, 32'hFFFF_FFFF},  // R11 unmapped
        {4'd11, 1'b1, 12'h040, 32'h0000_0000},
        {4'd11, 1'b0, 12'h00A, 32'hFFFF_FFFF},  // R11 misaligned
        {4'd11, 1'b1, 12'h008, 32'h2000_0400},
        {4'd7,  1'b1, 12'h014, 32'h0000_0000},  // R7 reads 0
        {4'd12, 1'b0, 12'h010, 32'hFFFF_FFFF},  // R12 read-only
        {4'd12, 1'b1, 12'h010, 32'h0000_0A0A},
        {4'd10, 1'b0, 12'h520, 32'hFFFF_FFFF},  // R10 mask r/w
        {4'd10, 1'b1, 12'h520, 32'h00FF_FFFF},
        {4'd10, 1'b0, 12'h520, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 enable", 32'(ch_enable), 32'h0);
        chk("R1 master_en", 32'(master_en), 32'h0);
        chk("R1 err_flag", 32'(err_flag), 32'h0);
        chk("R1 base_ptr", base_ptr, 32'h0);
        bus_read(12'h504, rd);
        chk("R1 done", rd, 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][44]) begin
                bus_read(VEC[i][43:32], rd);
                chk($sformatf("R%0d table entry %0d", VEC[i][48:45], i), rd, VEC[i][31:0]);
            end else begin
                bus_write(VEC[i][43:32], VEC[i][31:0]);
            end
        end

        // R2 R5 R6 R12 outputs follow registers
        chk("R2 ch_enable port", 32'(ch_enable), 32'h0000_00C0);
        chk("R2 ch_burst_only port", 32'(ch_burst_only), 32'h0000_FFFF);
        chk("R2 ch_use_alt port", 32'(ch_use_alt), 32'h0000_0080);
        chk("R5 prot_bits", 32'(prot_bits), 32'h7);
        chk("R6 alt_base port", alt_base, 32'h2000_0580);
        chk("R12 ch_wait_req", 32'(ch_wait_req), 32'h0000_0A0A);

        // R4 status with a live sequencer state
        seq_state = 4'h9;
        bus_read(12'h000, rd);
        chk("R4 status state", rd, 32'h0017_0091);

        // R13 read data holds between reads
        @(negedge clk);
        @(negedge clk);
        chk("R13 rdata hold", bus_rdata, 32'h0017_0091);

        // R7 software request pulse lasts one cycle
        bus_write(12'h014, 32'hFF00_0081);
        chk("R7 pulse", 32'(ch_sw_req), 32'h0000_0081);
        @(negedge clk);
        chk("R7 pulse ends", 32'(ch_sw_req), 32'h0);

        // R10 routing: mask channel 2
        bus_write(12'h520, 32'h0000_0004);
        @(negedge clk);
        ch_done_pulse = 24'h000006; ch_active = 24'h000006;
        #1;
        chk("R10 periph_done", 32'(periph_done), 32'h2);
        chk("R10 periph_active", 32'(periph_active), 32'h2);
        @(negedge clk);
        ch_done_pulse = '0; ch_active = '0;
        chk("R10 irq_done set", 32'(irq_done), 32'h1);
        bus_read(12'h504, rd);
        chk("R8 done sticky", rd, 32'h6);

        // R8 clear with a simultaneous completion keeps the bit
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h504; bus_wdata = 32'h6;
        ch_done_pulse = 24'h000004;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ch_done_pulse = '0;
        bus_read(12'h504, rd);
        chk("R8 set wins", rd, 32'h4);
        bus_write(12'h504, 32'h0000_0004);
        chk("R10 irq_done clear", 32'(irq_done), 32'h0);
        bus_read(12'h504, rd);
        chk("R8 cleared", rd, 32'h0);

        // R9 error flag
        @(negedge clk);
        bus_err_pulse = 1'b1;
        @(negedge clk);
        bus_err_pulse = 1'b0;
        chk("R9 set", 32'(err_flag), 32'h1);
        bus_write(12'h04C, 32'h0);
        chk("R9 write 0", 32'(err_flag), 32'h1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h04C; bus_wdata = 32'h1;
        bus_err_pulse = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_err_pulse = 1'b0;
        chk("R9 set wins", 32'(err_flag), 32'h1);
        bus_read(12'h04C, rd);
        chk("R9 readback", rd, 32'h1);
        bus_write(12'h04C, 32'h1);
        chk("R9 cleared", 32'(err_flag), 32'h0);

        // R1 reset clears state set above
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset enable", 32'(ch_enable), 32'h0);
        chk("R1 reset prio", 32'(ch_hi_prio), 32'h0);
        chk("R1 reset base", base_ptr, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule